// File: doc/BRIEF.md
# Receive Framer Event Latch Register

This block is a 16-bit sticky status word for a T1 receive framer. It gathers one-cycle event strobes and turns each into a bit that stays at 1 until software reads it. Some strobes report that an error or sync counter has wrapped back to zero. Others report that a counter has just advanced. Two more bits record any change, in either direction, of the terminal-frame and multiframe sync status levels.

Software reads the word over a small synchronous read port. Read data comes back one cycle after the read strobe. The read returns the word as it stood before the read took effect. All live bits are then cleared, whether the read targets this register's own address or the framer's interrupt summary address. If a new event arrives in the same cycle as a clearing read, it survives the clear, so no event is lost between two reads.

Top module: `rx_alarm_latch`

## Requirements
- R1: A synchronous reset clears all sixteen latch bits, and the read data output reads 0x0000.
- R2: Overflow strobe `ovf_evt[i]` sets latch bit 8+i. The mapping is: 7 framing-bit error, 6 CRC-6 error, 5 out-of-frame, 4 change-of-frame, 3 bipolar violation, 2 PRBS error, 1 PRBS CRC-6 multiframe, 0 multiframe out-of-frame.
- R3: `inc_fbe` (framing-bit error counter advanced) sets bit 5, and `inc_cof` (change-of-frame counter advanced) sets bit 4.
- R4: A change of `tsync_lvl` between two clock edges, 0 to 1 or 1 to 0, sets bit 7. A change of `msync_lvl` in either direction sets bit 6.
- R5: In the first clock after reset is released, the sync levels are only sampled. A level that is already 1 at that point sets no bit.
- R6: A read strobe at address `OWN_ADDR` puts the pre-clear latch word on `bus_rdata` one cycle later. Bits 3 to 0 always read 0.
- R7: A read at `OWN_ADDR` clears every latch bit.
- R8: A read at `SUM_ADDR` also clears every latch bit, and `bus_rdata` then reads 0x0000.
- R9: An event in the same cycle as a clearing read leaves its bit at 1 after the clear.
- R10: A read at any other address, or a cycle with no read, leaves the latches unchanged, and `bus_rdata` reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_evt | input | 8 | Counter wrap-to-zero strobes, one per counter |
| inc_fbe | input | 1 | Framing-bit error counter advance strobe |
| inc_cof | input | 1 | Change-of-frame counter advance strobe |
| tsync_lvl | input | 1 | Terminal-frame sync status level |
| msync_lvl | input | 1 | Multiframe sync status level |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Read address |
| bus_rdata | output | 16 | Registered read data |

## Verification
The collision that matters is an event and a clearing read landing in the same clock. In that cycle the read data must show the old word, and the latch must come out holding only the new event. The bench provokes this with a wrap strobe on one bit while a read at the register's own address is issued, and with all event sources firing during a summary-address read. A follow-up read must then show exactly the bit or bits that arrived with the clear.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int WORD_W  = 16;
  localparam int N_OVF   = 8;
  localparam int OVF_LSB = 8;
  localparam int B_TSYNC = 7;
  localparam int B_MSYNC = 6;
  localparam int B_FBE   = 5;
  localparam int B_COF   = 4;
  localparam int N_SYNC  = 2;
  localparam int SY_T    = 1;
  localparam int SY_M    = 0;

  function automatic logic [WORD_W-1:0] pack_events(
    input logic [N_OVF-1:0]  ovf,
    input logic [N_SYNC-1:0] chg,
    input logic              fbe,
    input logic              cof
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[OVF_LSB +: N_OVF] = ovf;
    w[B_TSYNC] = chg[SY_T];
    w[B_MSYNC] = chg[SY_M];
    w[B_FBE]   = fbe;
    w[B_COF]   = cof;
    return w;
  endfunction
endpackage

// File: rtl/rxl_sync_edge.sv
module rxl_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic primed_q;

  always_ff @(posedge clk) begin
    if (rst) primed_q <= 1'b0;
    else     primed_q <= 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl[g];
    end
    assign chg[g] = primed_q & (prev_q ^ lvl[g]);
  end
endmodule

// File: rtl/rxl_sticky_bank.sv
module rxl_sticky_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] lat_q
);
  logic [W-1:0] base;

  always_comb base = clr ? '0 : lat_q;

  always_ff @(posedge clk) begin
    if (rst) lat_q <= '0;
    else     lat_q <= base | evt;
  end
endmodule

// File: rtl/rxl_read_port.sv
module rxl_read_port #(
  parameter int              ADDR_W   = 8,
  parameter int              W        = 16,
  parameter logic [ADDR_W-1:0] OWN_ADDR = '0,
  parameter logic [ADDR_W-1:0] SUM_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      lat,
  output logic              clr,
  output logic [W-1:0]      rdata
);
  logic hit_own, hit_sum;

  always_comb begin
    hit_own = rd && (addr == OWN_ADDR);
    hit_sum = rd && (addr == SUM_ADDR);
    clr     = hit_own | hit_sum;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (hit_own) rdata <= lat;
    else              rdata <= '0;
  end
endmodule

// File: rtl/rx_alarm_latch.sv
module rx_alarm_latch #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [rxl_pkg::N_OVF-1:0]  ovf_evt,
  input  logic                       inc_fbe,
  input  logic                       inc_cof,
  input  logic                       tsync_lvl,
  input  logic                       msync_lvl,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  output logic [rxl_pkg::WORD_W-1:0] bus_rdata
);
  import rxl_pkg::*;

  logic [N_SYNC-1:0] sync_lvl, sync_chg;
  logic [WORD_W-1:0] evt_vec, lat_q;
  logic              rd_clr;

  always_comb begin
    sync_lvl       = '0;
    sync_lvl[SY_T] = tsync_lvl;
    sync_lvl[SY_M] = msync_lvl;
  end

  rxl_sync_edge #(.N(N_SYNC)) u_edge (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .chg(sync_chg)
  );

  always_comb evt_vec = pack_events(ovf_evt, sync_chg, inc_fbe, inc_cof);

  rxl_read_port #(
    .ADDR_W(ADDR_W), .W(WORD_W), .OWN_ADDR(OWN_ADDR), .SUM_ADDR(SUM_ADDR)
  ) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .lat(lat_q), .clr(rd_clr), .rdata(bus_rdata)
  );

  rxl_sticky_bank #(.W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .evt(evt_vec), .clr(rd_clr), .lat_q(lat_q)
  );
endmodule

// File: rtl/rx_alarm_latch_chk.sv
module rx_alarm_latch_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OWN_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h34
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        ovf_evt,
  input logic              inc_fbe,
  input logic              inc_cof,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_rdata,
  input logic [15:0]       lat,
  input logic [15:0]       evt
);
  logic rd_own, rd_sum;
  assign rd_own = bus_rd && (bus_addr == OWN_ADDR);
  assign rd_sum = bus_rd && (bus_addr == SUM_ADDR);

  p_reset_r1: assert property (@(posedge clk) rst |=> (lat == 16'h0 && bus_rdata == 16'h0));

  for (genvar g = 0; g < 8; g++) begin : g_ovf
    p_ovf_set_r2: assert property (@(posedge clk) disable iff (rst)
      ovf_evt[g] |=> lat[8+g]);
  end

  p_inc_fbe_r3: assert property (@(posedge clk) disable iff (rst) inc_fbe |=> lat[5]);
  p_inc_cof_r3: assert property (@(posedge clk) disable iff (rst) inc_cof |=> lat[4]);

  p_rdata_r6: assert property (@(posedge clk) disable iff (rst)
    rd_own |=> bus_rdata == $past(lat));
  p_rsvd_r6: assert property (@(posedge clk) disable iff (rst) bus_rdata[3:0] == 4'h0);

  p_clear_own_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_own && evt == 16'h0) |=> lat == 16'h0);
  p_clear_sum_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_sum && evt == 16'h0) |=> lat == 16'h0);

  p_keep_r9: assert property (@(posedge clk) disable iff (rst)
    ((rd_own || rd_sum) && evt != 16'h0) |=> (lat & $past(evt)) == $past(evt));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!(rd_own || rd_sum) && evt == 16'h0) |=> $stable(lat));
  p_rdata_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_own |=> bus_rdata == 16'h0);
endmodule

bind rx_alarm_latch rx_alarm_latch_chk #(
  .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR), .SUM_ADDR(SUM_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .inc_fbe(inc_fbe), .inc_cof(inc_cof),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .lat(lat_q), .evt(evt_vec)
);

// File: tb/rx_alarm_latch_bench.sv
module rx_alarm_latch_bench;
  localparam logic [7:0] OWN = 8'h24;
  localparam logic [7:0] SUM = 8'h34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ovf_evt = '0;
  logic        inc_fbe = 1'b0, inc_cof = 1'b0;
  logic        tsync_lvl = 1'b0, msync_lvl = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] mdl = '0;
  logic        m_primed = 1'b0;
  logic        m_ts = 1'b0, m_ms = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_q = 1'b0;

  always #10 clk = ~clk;

  rx_alarm_latch u_rx_alarm_latch (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .inc_fbe(inc_fbe), .inc_cof(inc_cof),
    .tsync_lvl(tsync_lvl), .msync_lvl(msync_lvl), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  // Drives one clock's worth of stimulus and updates the reference model.
  task automatic step(input logic [7:0] ovf, input logic fbe, input logic cof,
                      input logic ts, input logic ms, input logic rd,
                      input logic [7:0] addr, input string tag);
    logic [15:0] ev;
    logic        clr;
    ovf_evt = ovf; inc_fbe = fbe; inc_cof = cof;
    tsync_lvl = ts; msync_lvl = ms; bus_rd = rd; bus_addr = addr;
    ev = '0;
    ev[15:8] = ovf;
    ev[5] = fbe;
    ev[4] = cof;
    if (m_primed) begin
      ev[7] = (ts != m_ts);
      ev[6] = (ms != m_ms);
    end
    m_primed = 1'b1; m_ts = ts; m_ms = ms;
    clr = rd && (addr == OWN || addr == SUM);
    if (rd) begin
      exp_q.push_back((addr == OWN) ? mdl : 16'h0);
      tag_q.push_back(tag);
    end
    mdl = (clr ? 16'h0 : mdl) | ev;
    @(negedge clk);
  endtask

  task automatic idle();
    step(8'h0, 0, 0, m_ts, m_ms, 0, 8'h0, "idle");
  endtask

  task automatic rd_at(input logic [7:0] a, input string tag);
    step(8'h0, 0, 0, m_ts, m_ms, 1, a, tag);
  endtask

  // Monitor: compare read data one cycle after each read strobe.
  always @(posedge clk) rd_q <= bus_rd;
  always @(negedge clk) begin
    if (rd_q && !done) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog: run did not end (actual=hung expected=done)");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tsync_lvl = 1'b1; msync_lvl = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (bus_rdata !== 16'h0) begin
      bad++;
      $display("FAIL R1 in reset: rdata=%h expected=0000", bus_rdata);
    end
    rst = 1'b0;
    // R5: levels already 1 on the priming cycle set nothing
    step(8'h0, 0, 0, 1, 1, 0, 8'h0, "prime");
    idle();
    rd_at(OWN, "R1/R5 after reset");
    idle();

    // R2 each wrap strobe alone, R7 own read clears
    for (int i = 0; i < 8; i++) begin
      step(8'h1 << i, 0, 0, m_ts, m_ms, 0, 8'h0, "ovf");
      idle();
      rd_at(OWN, "R2 overflow bit");
      rd_at(OWN, "R7 cleared after own read");
    end

    // R3 increment strobes
    step(8'h0, 1, 0, m_ts, m_ms, 0, 8'h0, "fbe");
    step(8'h0, 0, 1, m_ts, m_ms, 0, 8'h0, "cof");
    rd_at(OWN, "R3 increment bits");

    // R4 sync changes in both directions
    step(8'h0, 0, 0, 0, m_ms, 0, 8'h0, "ts fall");
    rd_at(OWN, "R4 tsync 1->0");
    step(8'h0, 0, 0, 1, m_ms, 0, 8'h0, "ts rise");
    rd_at(OWN, "R4 tsync 0->1");
    step(8'h0, 0, 0, m_ts, 0, 0, 8'h0, "ms fall");
    rd_at(OWN, "R4 msync 1->0");
    step(8'h0, 0, 0, m_ts, 1, 0, 8'h0, "ms rise");
    idle();
    rd_at(OWN, "R4 msync 0->1");

    // R8 summary address clears, returns 0
    step(8'hA5, 1, 0, m_ts, m_ms, 0, 8'h0, "load");
    rd_at(SUM, "R8 summary read data");
    rd_at(OWN, "R8 cleared by summary read");

    // R10 other address and idle cycles keep the word
    step(8'h3C, 0, 1, m_ts, m_ms, 0, 8'h0, "load");
    rd_at(8'h11, "R10 other address data");
    idle(); idle();
    rd_at(8'h25, "R10 neighbour address data");
    rd_at(OWN, "R10 word unchanged");

    // R9 event in same cycle as own clearing read
    step(8'h80, 0, 0, m_ts, m_ms, 0, 8'h0, "load");
    step(8'h02, 0, 0, m_ts, m_ms, 1, OWN, "R9 pre-clear data");
    rd_at(OWN, "R9 event survives own clear");
    // R9 all sources during a summary read
    step(8'hFF, 1, 1, ~m_ts, ~m_ms, 1, SUM, "R9 summary data");
    rd_at(OWN, "R9 all events survive summary clear");
    rd_at(OWN, "R7 final empty");
    idle(); idle();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule